// File: doc/BRIEF.md
# Multi-Producer Stream Merge Channel

This block collects words from several producer streams and hands them to a single consumer. Every port, on both sides, uses a valid/ready handshake. A word moves only in a cycle where both valid and ready are high. A parameter picks the arbitration policy when the block is built.

- **Strict rotation:** the block serves inputs in a fixed cyclic order. The output interleaving is therefore fully deterministic.
- **First come:** whichever input has data wins.

Each input may get its own small buffer in front of the arbiter, or none, when its depth parameter is zero. A main buffer after the arbiter decouples the consumer. The consumer drains the main buffer at its own pace.

The block never drops, duplicates or reorders the words of any single producer. The words of different producers interleave according to the policy. Words carry no source tag. The data width, the port count and both buffer depths are parameters.

Top module: `stream_merge`

## Requirements
- R1: After a synchronous active-high reset, all buffers are empty and `m_valid` is 0. The rotation pointer starts at input 0, so in rotation mode the first word delivered comes from input 0.
- R2: In rotation mode (`POLICY` = 0), words are taken in the order input 0, 1, ..., N-1, 0, ... Each step takes exactly one word per input.
- R3: In rotation mode, while the current input has no word available, no word is taken from any other input.
- R4: In first-come mode (`POLICY` = 1), any input holding a word can be taken. When several hold words in the same cycle, the lowest index wins.
- R5: Words from any one input leave `m_data` in the order that input delivered them.
- R6: Every accepted input word appears exactly once on the output, with no loss and no duplication. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold steady.
- R7: With the consumer stalled, the block accepts at most MAIN_DEPTH + N*PORT_DEPTH words, then deasserts every `s_ready`.
- R8: With PORT_DEPTH = 0, at most one `s_ready` bit is high in any cycle. That bit belongs to the selected input, and it is high only while the main buffer has space.
- R9: A reset asserted mid-stream discards all buffered words, and `m_valid` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | N | Per-input word available |
| s_data | input | N*W | Per-input words; input i occupies bits [i*W +: W] |
| s_ready | output | N | Per-input acceptance |
| m_valid | output | 1 | Output word available |
| m_data | output | W | Output word |
| m_ready | input | 1 | Consumer accepts the output word |

## Verification
The bench builds two copies of the block, each with N = 4 and W = 8.

The first uses rotation with no per-input buffers and the default main depth of 2. This exposes the strict one-at-a-time input readiness, the stall of the rotation on a silent input, and the two-word backpressure limit.

The second uses first-come arbitration with two-word input buffers and a four-word main buffer. This brings the lowest-index tie rule, service of sparse input masks, and the combined twelve-word stall capacity within reach.

Each word encodes its source and sequence number, so the bench can check per-input order and the output count from `m_data` alone.

// File: rtl/merge_pkg.sv
package merge_pkg;

    // Arbitration policy selected by the POLICY parameter.
    typedef enum logic {
        ARB_ROTATE = 1'b0,
        ARB_FIRST  = 1'b1
    } arb_policy_e;

    // Read/write position bookkeeping of one buffer.
    typedef struct packed {
        logic push;
        logic pop;
    } buf_op_t;

    // Next index in a ring of n positions.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/merge_fifo.sv
module merge_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [W-1:0]                    in_data,
    output logic                            in_ready,
    output logic                            out_valid,
    output logic [W-1:0]                    out_data,
    input  logic                            out_ready,
    output logic [$clog2(DEPTH+2)-1:0]      count
);
    import merge_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 2);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_pos, rd_pos;
    logic [CW-1:0] fill;
    buf_op_t       op;

    assign in_ready  = (fill != CW'(DEPTH));
    assign out_valid = (fill != '0);
    assign out_data  = store[rd_pos];
    assign count     = fill;
    assign op.push   = in_valid && in_ready;
    assign op.pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos <= '0;
            rd_pos <= '0;
            fill   <= '0;
        end else begin
            if (op.push) begin
                store[wr_pos] <= in_data;
                wr_pos <= AW'(ring_next(int'(wr_pos), DEPTH));
            end
            if (op.pop)
                rd_pos <= AW'(ring_next(int'(rd_pos), DEPTH));
            case ({op.push, op.pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/merge_arbiter.sv
module merge_arbiter #(
    parameter int                    N      = 4,
    parameter merge_pkg::arb_policy_e POLICY = merge_pkg::ARB_ROTATE
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N-1:0]                      req,
    input  logic                              advance,
    output logic [N-1:0]                      grant,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr
);
    import merge_pkg::*;

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    // Pointer moves one step per transferred word. Rotation uses it to
    // pick the input; first-come keeps it only as a transfer phase.
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= PW'(ring_next(int'(ptr), N));
    end

    generate
        if (POLICY == ARB_ROTATE) begin : g_rotate
            always_comb begin
                grant = '0;
                grant[ptr] = req[ptr];
            end
        end else begin : g_first
            always_comb begin
                grant = '0;
                for (int i = N - 1; i >= 0; i--)
                    if (req[i]) grant = N'(1) << i;
            end
        end
    endgenerate
endmodule

// File: rtl/stream_merge.sv
module stream_merge #(
    parameter int                     W          = 8,
    parameter int                     N          = 4,
    parameter int                     MAIN_DEPTH = 2,
    parameter int                     PORT_DEPTH = 0,
    parameter merge_pkg::arb_policy_e POLICY     = merge_pkg::ARB_ROTATE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   s_valid,
    input  logic [N*W-1:0] s_data,
    output logic [N-1:0]   s_ready,
    output logic           m_valid,
    output logic [W-1:0]   m_data,
    input  logic           m_ready
);
    localparam int PW  = (N > 1) ? $clog2(N) : 1;
    localparam int MCW = $clog2(MAIN_DEPTH + 2);
    localparam int PCW = $clog2(PORT_DEPTH + 2);

    logic [N-1:0]   st_valid;
    logic [W-1:0]   st_data [N];
    logic [PCW-1:0] port_cnt [N];
    logic [N-1:0]   grant;
    logic [PW-1:0]  rr_ptr;
    logic           main_in_ready;
    logic [W-1:0]   sel_data;
    logic [MCW-1:0] main_count;
    logic           take;

    assign take = (|grant) && main_in_ready;

    generate
        for (genvar i = 0; i < N; i++) begin : g_port
            if (PORT_DEPTH > 0) begin : g_buf
                merge_fifo #(.W(W), .DEPTH(PORT_DEPTH)) port_fifo_i (
                    .clk       (clk),
                    .rst       (rst),
                    .in_valid  (s_valid[i]),
                    .in_data   (s_data[i*W +: W]),
                    .in_ready  (s_ready[i]),
                    .out_valid (st_valid[i]),
                    .out_data  (st_data[i]),
                    .out_ready (grant[i] && main_in_ready),
                    .count     (port_cnt[i])
                );
            end else begin : g_direct
                assign st_valid[i] = s_valid[i];
                assign st_data[i]  = s_data[i*W +: W];
                assign s_ready[i]  = grant[i] && main_in_ready;
                assign port_cnt[i] = '0;
            end
        end
    endgenerate

    merge_arbiter #(.N(N), .POLICY(POLICY)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .req     (st_valid),
        .advance (take),
        .grant   (grant),
        .ptr     (rr_ptr)
    );

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) sel_data = sel_data | st_data[i];
    end

    merge_fifo #(.W(W), .DEPTH(MAIN_DEPTH)) main_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (|grant),
        .in_data   (sel_data),
        .in_ready  (main_in_ready),
        .out_valid (m_valid),
        .out_data  (m_data),
        .out_ready (m_ready),
        .count     (main_count)
    );
endmodule

// File: rtl/stream_merge_checker.sv
module stream_merge_checker #(
    parameter int                     W          = 8,
    parameter int                     N          = 4,
    parameter int                     MAIN_DEPTH = 2,
    parameter int                     PORT_DEPTH = 0,
    parameter merge_pkg::arb_policy_e POLICY     = merge_pkg::ARB_ROTATE
) (
    input logic                                clk,
    input logic                                rst,
    input logic [N-1:0]                        s_ready,
    input logic                                m_valid,
    input logic [W-1:0]                        m_data,
    input logic                                m_ready,
    input logic [N-1:0]                        grant,
    input logic [N-1:0]                        st_valid,
    input logic [((N > 1) ? $clog2(N) : 1)-1:0]   rr_ptr,
    input logic [$clog2(MAIN_DEPTH+2)-1:0]     main_count,
    input logic [$clog2(PORT_DEPTH+2)-1:0]     port_cnt [N]
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !m_valid); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R6

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        main_count <= ($clog2(MAIN_DEPTH+2))'(MAIN_DEPTH)); // R7

    generate
        for (genvar i = 0; i < N; i++) begin : g_pc
            AST_PORT_BOUND: assert property (@(posedge clk) disable iff (rst)
                port_cnt[i] <= ($clog2(PORT_DEPTH+2))'(PORT_DEPTH)); // R7
        end
        if (POLICY == merge_pkg::ARB_ROTATE) begin : g_rot
            AST_ROTATE_WAIT: assert property (@(posedge clk) disable iff (rst)
                !st_valid[rr_ptr] |-> (grant == '0)); // R3
        end else begin : g_first
            AST_FIRST_WINS: assert property (@(posedge clk) disable iff (rst)
                (st_valid != '0) |-> (grant != '0)); // R4
        end
        if (PORT_DEPTH == 0) begin : g_zero
            AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
                $onehot0(s_ready)); // R8
        end
    endgenerate
endmodule

bind stream_merge stream_merge_checker #(
    .W(W), .N(N), .MAIN_DEPTH(MAIN_DEPTH), .PORT_DEPTH(PORT_DEPTH), .POLICY(POLICY)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .s_ready    (s_ready),
    .m_valid    (m_valid),
    .m_data     (m_data),
    .m_ready    (m_ready),
    .grant      (grant),
    .st_valid   (st_valid),
    .rr_ptr     (rr_ptr),
    .main_count (main_count),
    .port_cnt   (port_cnt)
);

// File: tb/stream_merge_tb.sv
module stream_merge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int W = 8;
    localparam int NV = 6;
    // sel (0 rotation dut, 1 first-come dut), input mask, words per input, ready mode
    localparam int VEC [NV][4] = '{
        '{0, 15, 16, 0},
        '{0, 15, 16, 1},
        '{1, 15, 16, 0},
        '{1, 12,  8, 1},
        '{1, 10, 16, 1},
        '{0, 15,  5, 1}
    };

    logic clk = 0;
    logic rst = 1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           sel = 0;
    logic [N-1:0]   s_valid = '0;
    logic [N*W-1:0] s_data = '0;
    logic           m_ready = 0;

    logic [N-1:0] rr_s_ready, lb_s_ready;
    logic         rr_m_valid, lb_m_valid;
    logic [W-1:0] rr_m_data, lb_m_data;

    stream_merge #(.W(W), .N(N), .MAIN_DEPTH(2), .PORT_DEPTH(0),
                   .POLICY(merge_pkg::ARB_ROTATE)) dut_i (
        .clk(clk), .rst(rst),
        .s_valid(sel ? '0 : s_valid), .s_data(s_data), .s_ready(rr_s_ready),
        .m_valid(rr_m_valid), .m_data(rr_m_data), .m_ready(!sel && m_ready));

    stream_merge #(.W(W), .N(N), .MAIN_DEPTH(4), .PORT_DEPTH(2),
                   .POLICY(merge_pkg::ARB_FIRST)) dut_lb_i (
        .clk(clk), .rst(rst),
        .s_valid(sel ? s_valid : '0), .s_data(s_data), .s_ready(lb_s_ready),
        .m_valid(lb_m_valid), .m_data(lb_m_data), .m_ready(sel && m_ready));

    int tests = 0, fails = 0, cyc = 0;
    bit timed_out = 0;
    int sent [N];
    int exp_seq [N];
    bit fire [N];
    int received, accepted, first_src, order_err, rot_err, max_fire;
    int mask, limit, rmode;
    bit stall;

    task automatic check(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_run();
        for (int p = 0; p < N; p++) begin sent[p] = 0; exp_seq[p] = 0; fire[p] = 0; end
        received = 0; accepted = 0; first_src = -1; order_err = 0; rot_err = 0; max_fire = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; s_valid = '0; m_ready = 0;
        @(negedge clk); @(negedge clk); rst = 0;
        clear_run();
    endtask

    task automatic step();
        int nf;
        logic [N-1:0] rdy;
        logic mv;
        logic [W-1:0] md;
        @(negedge clk);
        cyc++;
        if (cyc > 100000) timed_out = 1;
        for (int p = 0; p < N; p++) if (fire[p]) sent[p]++;
        for (int p = 0; p < N; p++) begin
            s_valid[p] = mask[p] && (sent[p] < limit);
            s_data[p*W +: W] = {2'(p), 6'(sent[p])};
        end
        m_ready = !stall && ((rmode == 0) || (cyc % 3 != 0));
        #1;
        rdy = sel ? lb_s_ready : rr_s_ready;
        mv  = sel ? lb_m_valid : rr_m_valid;
        md  = sel ? lb_m_data  : rr_m_data;
        nf = 0;
        for (int p = 0; p < N; p++) begin
            fire[p] = s_valid[p] && rdy[p];
            if (fire[p]) begin nf++; accepted++; end
        end
        if (nf > max_fire) max_fire = nf;
        if (mv && m_ready) begin
            int src;
            src = int'(md[7:6]);
            if (first_src < 0) first_src = src;
            if (int'(md[5:0]) != exp_seq[src]) order_err++;
            exp_seq[src]++;
            if (src != received % N) rot_err++;
            received++;
        end
    endtask

    initial begin
        stall = 0; mask = 0; limit = 0; rmode = 0;
        clear_run();
        do_reset();
        #1;
        check(!rr_m_valid && !lb_m_valid, "R1 reset empty", int'(rr_m_valid | lb_m_valid), 0);

        for (int v = 0; v < NV; v++) begin
            int total, lowest;
            sel = VEC[v][0][0]; mask = VEC[v][1]; limit = VEC[v][2]; rmode = VEC[v][3];
            do_reset();
            total = 0; lowest = -1;
            for (int p = 0; p < N; p++) if (mask[p]) begin
                total += limit;
                if (lowest < 0) lowest = p;
            end
            for (int k = 0; k < 3000 && received < total && !timed_out; k++) step();
            for (int k = 0; k < 10; k++) step();
            check(received == total, "R6 word count", received, total);
            check(order_err == 0, "R5 per-input order", order_err, 0);
            if (sel == 0) begin
                check(rot_err == 0, "R2 rotation order", rot_err, 0);
                check(first_src == 0, "R1 first word from input 0", first_src, 0);
                check(max_fire <= 1, "R8 single ready", max_fire, 1);
            end else begin
                check(first_src == lowest, "R4 lowest index wins", first_src, lowest);
            end
        end

        // R3: rotation stalls on a silent input 0
        sel = 0; mask = 14; limit = 8; rmode = 0;
        do_reset();
        for (int k = 0; k < 20; k++) step();
        check(accepted == 0, "R3 rotation waits accepted", accepted, 0);
        check(received == 0, "R3 rotation waits output", received, 0);

        // R7: stalled consumer, rotation copy holds MAIN_DEPTH words
        sel = 0; mask = 15; limit = 16; stall = 1;
        do_reset();
        for (int k = 0; k < 20; k++) step();
        check(accepted == 2, "R7 backpressure rotation", accepted, 2);
        check(rr_m_valid == 1, "R6 held output valid", int'(rr_m_valid), 1);

        // R9: reset mid-stream discards buffered words
        do_reset();
        #1;
        check(rr_m_valid == 0, "R9 reset flushes", int'(rr_m_valid), 0);

        // R7: first-come copy holds 4 + 4*2 words
        sel = 1; mask = 15; limit = 16; stall = 1;
        do_reset();
        for (int k = 0; k < 30; k++) step();
        check(accepted == 12, "R7 backpressure first-come", accepted, 12);
        do_reset();
        #1;
        check(lb_m_valid == 0, "R9 reset flushes first-come", int'(lb_m_valid), 0);
        stall = 0;

        if (timed_out) check(0, "watchdog", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule